// File: doc/BRIEF.md
# Posted-write buffer with read forwarding

The block sits between a requester and main memory and absorbs writes so the requester never waits for memory on a store. A write (block address plus data) is finished the moment the buffer takes it, which happens whenever an entry is free. Buffered writes stay in a bounded queue until a drain condition fires. Two events start a drain: the queue filling up, or the memory bus staying quiet for a software-chosen number of cycles. A drain runs until the queue is empty. The oldest entry is sent first.

Reads never wait behind buffered writes. Each read compares its block address against every occupied entry. On a match, the data of the youngest matching write returns on the response port one cycle later, and memory is not touched. A read that finds no match takes the single memory command slot ahead of any pending drain. The memory's own read data goes back to the requester outside this block. The memory side is one registered command with a valid/ready handshake, and that command holds steady while it is stalled.

Top module: `wbuf_fwd`

## Requirements
- R1: A write presented while fewer than DEPTH entries are occupied is accepted in that same cycle (`req_ready` high with `req_write`=1), and accepting it puts nothing on the memory port.
- R2: The buffer holds at most DEPTH writes. With all DEPTH entries occupied, `req_ready` is low for a write.
- R3: A read that misses the buffer reaches the memory port before any older write still in the buffer.
- R4: A read is compared against every occupied entry, not only the newest or the oldest one.
- R5: On a read hit, `rsp_valid` is high in the cycle after acceptance, and `rsp_data` equals the data of the most recently accepted write to that block address. No memory read is issued.
- R6: Once the buffer is full, a drain starts on the next free memory command slot and continues until the buffer is empty.
- R7: Drained writes appear on the memory port (`mem_write`=1, `mem_addr`, `mem_wdata`) in the order the writes were accepted, one command per entry, including repeated writes to the same block.
- R8: If `bus_idle` is high and `req_valid` is low for `idle_limit` consecutive cycles while the buffer is not empty, the oldest write is registered onto the memory port at the following clock edge, and the drain continues until the buffer is empty.
- R9: Any cycle with `bus_idle` low or `req_valid` high restarts the idle count from zero.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` do not change.
- R11: During and right after the synchronous active-high reset, `mem_valid` and `rsp_valid` are low and the buffer is empty, so a write sees `req_ready` high.
- R12: A read is accepted only when the memory command slot is free or is being freed in that cycle. A missing read becomes a memory command with `mem_write`=0 and `mem_addr` equal to the read's block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester presents a read or write |
| req_ready | output | 1 | Request accepted this cycle; for a write this is its completion |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Block address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Forwarded read data valid |
| rsp_data | output | DW | Forwarded read data |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory accepts the command |
| mem_write | output | 1 | 1 = writeback, 0 = read |
| mem_addr | output | AW | Memory command block address |
| mem_wdata | output | DW | Writeback data |
| bus_idle | input | 1 | Memory bus currently idle |
| idle_limit | input | TW | Idle cycles before a drain starts |

## Verification
The stimulus first writes the same block twice around a write to another block, then reads both blocks. The repeated block tells an oldest-match search apart from a youngest-match search, and the second block shows that entries other than the newest are searched. A read miss issued while three writes are buffered separates a read-priority slot from a strict FIFO, and stalling memory during that miss exposes any command that moves before it is accepted. Filling the queue tests the full trigger, the drain order and the write stall. An idle window broken by one busy cycle tells a counter that restarts apart from one that only pauses, and the exact cycle of the first writeback is checked against the programmed limit.

// File: rtl/wbf_pkg.sv
package wbf_pkg;
  typedef enum logic [1:0] {
    CMD_KEEP  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_DRAIN = 2'd2,
    CMD_CLEAR = 2'd3
  } cmd_sel_t;
endpackage

// File: rtl/wbf_store.sv
module wbf_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic [CW-1:0] fill,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // entry storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[tail_q] <= push_addr;
      data_mem[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      fill_q <= '0;
    end else begin
      if (push) tail_q <= bump(tail_q);
      if (pop)  head_q <= bump(head_q);
      fill_q <= fill_q + CW'(push) - CW'(pop);
    end
  end

  // youngest-match search: walk from oldest to newest, later hits win
  always_comb begin
    int slot;
    hit      = 1'b0;
    hit_data = '0;
    for (int k = DEPTH; k >= 1; k--) begin
      slot = int'(tail_q) - k;
      if (slot < 0) slot = slot + DEPTH;
      if (CW'(k) <= fill_q && addr_mem[slot] == look_addr) begin
        hit      = 1'b1;
        hit_data = data_mem[slot];
      end
    end
  end

  assign fill      = fill_q;
  assign head_addr = addr_mem[head_q];
  assign head_data = data_mem[head_q];
endmodule

// File: rtl/wbf_idle.sv
module wbf_idle #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_idle,
  input  logic          req_seen,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst || !bus_idle || req_seen) quiet_q <= '0;
    else if (quiet_q != '1)           quiet_q <= quiet_q + 1'b1;
  end

  assign expired = (quiet_q >= limit);
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int TW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          bus_idle,
  input  logic [TW-1:0] idle_limit
);
  logic [CW-1:0] fill_cnt, fill_next;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;
  logic          hit, idle_exp;
  logic          full, empty, slot_free;
  logic          rd_go, wr_go, rd_miss, drain_on, pop;
  logic          drain_q;
  cmd_sel_t      sel;

  logic          mem_valid_q, mem_write_q, rsp_valid_q;
  logic [AW-1:0] mem_addr_q;
  logic [DW-1:0] mem_wdata_q, rsp_data_q;

  wbf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .push(wr_go), .push_addr(req_addr), .push_data(req_wdata),
    .pop(pop), .look_addr(req_addr),
    .fill(fill_cnt), .head_addr(head_addr), .head_data(head_data),
    .hit(hit), .hit_data(hit_data)
  );

  wbf_idle #(.TW(TW)) u_idle (
    .clk(clk), .rst(rst), .bus_idle(bus_idle), .req_seen(req_valid),
    .limit(idle_limit), .expired(idle_exp)
  );

  always_comb begin
    full      = (fill_cnt == CW'(DEPTH));
    empty     = (fill_cnt == '0);
    slot_free = !mem_valid_q || mem_ready;
    rd_go     = req_valid && !req_write && slot_free;
    wr_go     = req_valid && req_write && !full;
    rd_miss   = rd_go && !hit;
    drain_on  = drain_q || full || idle_exp;
    pop       = drain_on && !empty && slot_free && !rd_miss;
    fill_next = fill_cnt + CW'(wr_go) - CW'(pop);
    if (rd_miss)        sel = CMD_READ;
    else if (pop)       sel = CMD_DRAIN;
    else if (mem_ready) sel = CMD_CLEAR;
    else                sel = CMD_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q     <= 1'b0;
      mem_valid_q <= 1'b0;
      mem_write_q <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      drain_q     <= drain_on && (fill_next != '0);
      rsp_valid_q <= rd_go && hit;
      if (rd_go && hit) rsp_data_q <= hit_data;
      unique case (sel)
        CMD_READ: begin
          mem_valid_q <= 1'b1;
          mem_write_q <= 1'b0;
          mem_addr_q  <= req_addr;
          mem_wdata_q <= '0;
        end
        CMD_DRAIN: begin
          mem_valid_q <= 1'b1;
          mem_write_q <= 1'b1;
          mem_addr_q  <= head_addr;
          mem_wdata_q <= head_data;
        end
        CMD_CLEAR: mem_valid_q <= 1'b0;
        default:   ;
      endcase
    end
  end

  assign req_ready = req_write ? !full : slot_free;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign mem_valid = mem_valid_q;
  assign mem_write = mem_write_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
endmodule

// File: rtl/wbuf_fwd_chk.sv
module wbuf_fwd_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [CW-1:0] fill
);
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  p_write_kept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_ready) |=> (fill != '0));

  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write && req_ready));

  p_read_served_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_ready) |=> (rsp_valid || (mem_valid && !mem_write)));

  p_full_drains_r6: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH) && (!mem_valid || mem_ready) && !(req_valid && !req_write))
      |=> (mem_valid && mem_write));
endmodule

bind wbuf_fwd wbuf_fwd_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .fill(fill_cnt)
);

// File: tb/wbuf_fwd_test.sv
`timescale 1ns/1ps
module wbuf_fwd_test;
  localparam int DEPTH = 4, AW = 12, DW = 16, TW = 8;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_valid, mem_ready, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic bus_idle;
  logic [TW-1:0] idle_limit;

  always #2 clk = ~clk;

  wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .bus_idle(bus_idle), .idle_limit(idle_limit)
  );

  int tests = 0, fails = 0, wr_seen = 0, rd_seen = 0, wait_cyc = 0;
  bit done = 1'b0;
  logic [AW+DW-1:0] exp_wr[$];
  logic [AW-1:0]    exp_rd[$];
  logic [DW-1:0]    exp_rsp[$];
  logic [AW+DW-1:0] e_wr;
  logic [AW-1:0]    e_rd;
  logic [DW-1:0]    e_rsp;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          wr_seen++;
          if (exp_wr.size() == 0) chk(0, "R7", "unexpected writeback", {mem_addr, mem_wdata}, 0);
          else begin
            e_wr = exp_wr.pop_front();
            chk({mem_addr, mem_wdata} == e_wr, "R7", "writeback order/content",
                {mem_addr, mem_wdata}, e_wr);
          end
        end else begin
          rd_seen++;
          if (exp_rd.size() == 0) chk(0, "R5", "unexpected memory read", mem_addr, 0);
          else begin
            e_rd = exp_rd.pop_front();
            chk(mem_addr == e_rd, "R12", "memory read address", mem_addr, e_rd);
          end
        end
      end
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) chk(0, "R5", "unexpected response", rsp_data, 0);
        else begin
          e_rsp = exp_rsp.pop_front();
          chk(rsp_data == e_rsp, "R5", "forwarded data", rsp_data, e_rsp);
        end
      end
    end
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    wait_cyc = 0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; wait_cyc++; end
    exp_wr.push_back({a, d});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit hit, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (hit) exp_rsp.push_back(d);
    else     exp_rd.push_back(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b1; req_addr = '0; req_wdata = '0;
    mem_ready = 1'b1; bus_idle = 1'b0; idle_limit = 8'd50;
    repeat (3) @(negedge clk);
    chk(mem_valid == 1'b0 && rsp_valid == 1'b0, "R11", "outputs in reset", {mem_valid, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "write ready after reset", req_ready, 1);

    wr(12'h010, 16'h1111);
    chk(wait_cyc == 0, "R1", "write stall cycles", wait_cyc, 0);
    wr(12'h020, 16'h2222);
    wr(12'h010, 16'h3333);
    chk(wait_cyc == 0, "R1", "write stall cycles", wait_cyc, 0);
    chk(mem_valid == 1'b0 && wr_seen == 0, "R1", "memory traffic on write", mem_valid, 0);

    rd(12'h010, 1'b1, 16'h3333);
    chk(rsp_valid == 1'b1, "R5", "response one cycle after read", rsp_valid, 1);
    rd(12'h020, 1'b1, 16'h2222);
    chk(rsp_valid == 1'b1, "R4", "older entry searched", rsp_valid, 1);

    rd(12'h0FF, 1'b0, '0);
    @(negedge clk);
    chk(rd_seen == 1 && wr_seen == 0, "R3", "read ahead of writes (reads,writes)",
        {rd_seen[15:0], wr_seen[15:0]}, 32'h0001_0000);

    @(posedge clk); #1 mem_ready = 1'b0;
    @(negedge clk);
    rd(12'h0EE, 1'b0, '0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_valid && !mem_write && mem_addr == 12'h0EE, "R10", "stalled command held",
          {mem_valid, mem_addr}, {1'b1, 12'h0EE});
    end
    @(posedge clk); #1 mem_ready = 1'b1;
    @(negedge clk);

    wr(12'h030, 16'h4444);
    chk(req_ready == 1'b0, "R2", "write ready when full", req_ready, 0);
    repeat (8) @(negedge clk);
    chk(exp_wr.size() == 0 && wr_seen == 4, "R6", "writebacks after full", wr_seen, 4);

    idle_limit = 8'd6;
    wr(12'h040, 16'h5555);
    wr(12'h050, 16'h6666);
    bus_idle = 1'b1;
    repeat (4) @(negedge clk);
    bus_idle = 1'b0;
    @(negedge clk);
    bus_idle = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(mem_valid == 1'b0, "R9", "early drain after busy cycle", mem_valid, 0);
    end
    @(negedge clk);
    chk(mem_valid && mem_write, "R8", "drain at idle limit", {mem_valid, mem_write}, 2'b11);
    repeat (6) @(negedge clk);
    chk(exp_wr.size() == 0 && wr_seen == 6, "R8", "idle drain empties buffer", wr_seen, 6);
    bus_idle = 1'b0;

    chk(exp_rd.size() == 0 && exp_rsp.size() == 0, "R12", "pending expectations",
        exp_rd.size() + exp_rsp.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule